// File: doc/BRIEF.md
# Double-Buffered Serial Character Transmitter

This block turns host-written characters into asynchronous serial frames. The host writes a character into a holding register with a single-cycle strobe. The value on the ninth-bit input is captured with that write. The block moves the character into an internal shift register that the host cannot reach, and sends it one bit per baud tick. A new character can wait in the holding register while the previous frame is still going out, so frames can follow each other with no gap.

The configuration inputs set the character length (8 or 9 slots) and the number of stop bits (1 or 2). They can also turn the last character slot into a parity bit, either even or odd, or into an address marker. Clearing the enable abandons the frame in flight and puts the serial pin in high impedance. The baud tick comes from outside the block.

The shift unit is a four-state machine:
- `TX_OFF`: disabled, output floated.
- `TX_EMPTY`: enabled, nothing loaded.
- `TX_ARMED`: loaded, waiting for a tick.
- `TX_SHIFT`: frame on the line.

Its transitions are:
- *enable*: OFF→EMPTY.
- *load*: EMPTY→ARMED.
- *launch*: ARMED→SHIFT on a tick.
- *advance*: SHIFT→SHIFT on a tick within a frame.
- *chain*: SHIFT→SHIFT on the final tick when a character is waiting.
- *finish*: SHIFT→EMPTY on the final tick when none is waiting.
- *abort*: any state→OFF when the enable is low.

Top module: `uart_tx_dbuf`

## Requirements
- R1: A frame on `ser_out` has the following bit order, and each bit lasts exactly one baud-tick interval, with bit changes only at tick edges:
  - one low start bit;
  - the character slots, least significant first;
  - the stop bits, all high.
- R2: With `cfg_nine`=0 the character has 8 slots, taken from `wr_data[7:0]`. With `cfg_nine`=1 it has 9 slots, and slot 8 holds the `wr_nine` value captured with the write.
- R3: With `cfg_par_en`=1 the last slot (slot 7 or 8) is replaced by a parity bit computed over the slots below it. With `cfg_par_odd`=0 that parity is even (the total number of ones is even). With `cfg_par_odd`=1 it is odd.
- R4: With `cfg_addr_en`=1 and `cfg_par_en`=0, the last slot carries the captured `wr_nine` value as an address marker, in both 8- and 9-slot modes. Parity takes priority over the address marker when both are set.
- R5: With `cfg_two_stop`=0 the frame has one stop bit; with 1 it has two. Configuration is sampled when the character moves into the shift register.
- R6: A write sets the holding register full, so `hold_empty` goes to 0 in the next cycle. If the block is enabled and the shift register is empty, the character moves on one clock later and `hold_empty` returns to 1. A write to a full holding register replaces its contents.
- R7: A waiting character is not taken while a frame is in flight. It is taken at the tick that ends the last stop bit, and its start bit follows with no idle bit between the frames.
- R8: A frame starts only when three conditions hold: the block is enabled, a character is present, and a baud tick arrives. A character written while disabled stays in the holding register and is sent after enabling.
- R9: One clock after `tx_en` falls, `ser_oe` is 0 and the frame in flight is discarded. A character waiting in the holding register is kept and is sent in full after re-enabling.
- R10: `tx_idle` is 1 only when the holding register is empty and no frame is loaded or in flight. While the block is enabled and idle, `ser_out` is 1.
- R11: After reset, `ser_oe`=0, `hold_empty`=1 and `tx_idle`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable; low aborts and floats the line |
| wr_stb | input | 1 | Holding-register write strobe |
| wr_data | input | 8 | Character data |
| wr_nine | input | 1 | Ninth-bit / marker value captured on write |
| cfg_nine | input | 1 | 1 = 9-slot character, 0 = 8-slot |
| cfg_par_en | input | 1 | Last slot becomes parity |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_addr_en | input | 1 | Last slot becomes address marker |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| ser_out | output | 1 | Serial data |
| ser_oe | output | 1 | Output enable for the serial pin driver |
| hold_empty | output | 1 | Holding register is empty |
| tx_idle | output | 1 | Nothing waiting, loaded or in flight |

## Verification
The hardest case to reach is the chain transition. It needs a second character waiting in the holding register at the exact tick that ends the previous frame's last stop bit. The bench gets there by forking: one branch follows the first frame bit by bit, while a second branch writes twice into the holding register during that frame. The checker then continues directly into the second frame with no fresh start search, so any idle gap or early reload shows up as a wrong bit. Aborts are reached the same way, by dropping the enable partway through the data slots while a character waits behind the frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [1:0] {
        TX_OFF   = 2'd0,
        TX_EMPTY = 2'd1,
        TX_ARMED = 2'd2,
        TX_SHIFT = 2'd3
    } tx_state_e;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_nine,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              nine
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
            nine <= 1'b0;
        end else if (wr_stb) begin
            full <= 1'b1;
            data <= wr_data;
            nine <= wr_nine;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer #(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 4,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  logic               nine,
    input  logic               cfg_nine,
    input  logic               cfg_par_en,
    input  logic               cfg_par_odd,
    input  logic               cfg_addr_en,
    input  logic               cfg_two_stop,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   flen
);
    localparam int CHR_W = DATA_W + 1;

    logic [CHR_W-1:0] chr;
    logic             par;
    int               clen;
    int               slot;

    always_comb begin
        chr  = {nine, data};
        clen = cfg_nine ? CHR_W : DATA_W;
        slot = clen - 1;
        par  = 1'b0;
        for (int i = 0; i < CHR_W; i++) begin
            if (i < slot) par = par ^ chr[i];
        end
        if (cfg_par_en)       chr[slot] = par ^ cfg_par_odd;
        else if (cfg_addr_en) chr[slot] = nine;
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < CHR_W; i++) begin
            if (i < clen) frame[i+1] = chr[i];
        end
        flen = CNT_W'(1 + clen + (cfg_two_stop ? 2 : 1));
    end
endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
    import uart_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 4,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic               baud_tick,
    input  logic               hold_full,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   flen,
    output logic               take,
    output logic               ser_out,
    output logic               ser_oe,
    output logic               busy
);
    tx_state_e          state_q, state_d;
    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               last_bit;

    assign last_bit = (cnt_q == CNT_W'(1));

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            TX_OFF:   state_d = TX_EMPTY;
            TX_EMPTY: if (hold_full) begin
                          take    = 1'b1;
                          state_d = TX_ARMED;
                      end
            TX_ARMED: if (baud_tick) state_d = TX_SHIFT;
            TX_SHIFT: if (baud_tick && last_bit) begin
                          if (hold_full) take = 1'b1;
                          else           state_d = TX_EMPTY;
                      end
        endcase
        if (!tx_en) begin
            state_d = TX_OFF;
            take    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_OFF;
            sh_q    <= '1;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == TX_OFF) begin
                sh_q  <= '1;
                cnt_q <= '0;
            end else if (take) begin
                sh_q  <= frame;
                cnt_q <= flen;
            end else if (state_q == TX_SHIFT && baud_tick && !last_bit) begin
                sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    always_comb begin
        ser_oe  = (state_q != TX_OFF);
        ser_out = (state_q == TX_SHIFT) ? sh_q[0] : 1'b1;
        busy    = (state_q == TX_ARMED) || (state_q == TX_SHIFT);
    end
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_nine,
    input  logic              cfg_nine,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_addr_en,
    input  logic              cfg_two_stop,
    input  logic              baud_tick,
    output logic              ser_out,
    output logic              ser_oe,
    output logic              hold_empty,
    output logic              tx_idle
);
    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic               hold_full;
    logic [DATA_W-1:0]  hold_data;
    logic               hold_nine;
    logic               take;
    logic               busy;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   flen;

    uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .wr_nine (wr_nine),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data),
        .nine    (hold_nine)
    );

    uart_tx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
        .data         (hold_data),
        .nine         (hold_nine),
        .cfg_nine     (cfg_nine),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_addr_en  (cfg_addr_en),
        .cfg_two_stop (cfg_two_stop),
        .frame        (frame),
        .flen         (flen)
    );

    uart_tx_seq #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .baud_tick (baud_tick),
        .hold_full (hold_full),
        .frame     (frame),
        .flen      (flen),
        .take      (take),
        .ser_out   (ser_out),
        .ser_oe    (ser_oe),
        .busy      (busy)
    );

    assign hold_empty = !hold_full;
    assign tx_idle    = !hold_full && !busy;
endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic wr_stb,
    input logic baud_tick,
    input logic ser_out,
    input logic ser_oe,
    input logic hold_empty,
    input logic tx_idle
);
    a_r1_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_oe && $past(ser_oe) && (ser_out != $past(ser_out))) |-> $past(baud_tick));

    a_r6_fill_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_empty) |-> $past(wr_stb));

    a_r7_drain_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_empty) |-> $past(tx_en));

    a_r9_float_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!tx_en) |-> !ser_oe);

    a_r10_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle && ser_oe) |-> ser_out);
endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .wr_stb     (wr_stb),
    .baud_tick  (baud_tick),
    .ser_out    (ser_out),
    .ser_oe     (ser_oe),
    .hold_empty (hold_empty),
    .tx_idle    (tx_idle)
);

// File: tb/uart_tx_dbuf_test.sv
module uart_tx_dbuf_test;
    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_nine = 1'b0;
    logic       cfg_nine = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_addr_en = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       baud_tick = 1'b0;
    logic       ser_out, ser_oe, hold_empty, tx_idle;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    uart_tx_dbuf uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_stb(wr_stb),
        .wr_data(wr_data), .wr_nine(wr_nine), .cfg_nine(cfg_nine),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_addr_en(cfg_addr_en), .cfg_two_stop(cfg_two_stop),
        .baud_tick(baud_tick), .ser_out(ser_out), .ser_oe(ser_oe),
        .hold_empty(hold_empty), .tx_idle(tx_idle)
    );

    initial begin
        int tcnt = 0;
        forever begin
            @(negedge clk);
            tcnt++;
            baud_tick = (tcnt % P == 0);
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_frame(input logic [7:0] d, input logic n9,
                                output logic [11:0] bits, output int len);
        logic [8:0] c;
        int n, ones;
        n = cfg_nine ? 9 : 8;
        c = {n9, d};
        ones = 0;
        for (int i = 0; i < n - 1; i++) ones += c[i];
        if (cfg_par_en)       c[n-1] = cfg_par_odd ? ~ones[0] : ones[0];
        else if (cfg_addr_en) c[n-1] = n9;
        bits = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < n; i++) bits[i+1] = c[i];
        len = 1 + n + (cfg_two_stop ? 2 : 1);
    endtask

    task automatic write_char(input logic [7:0] d, input logic n9);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = d; wr_nine = n9;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wait_start(input string req);
        int k = 0;
        while (!(ser_oe && !ser_out) && k < 30 * P) begin
            @(negedge clk);
            k++;
        end
        chk(ser_oe && !ser_out, req, ser_out, 0);
    endtask

    // Starts at the first negedge of the start bit; returns at the first
    // negedge after the final stop bit.
    task automatic check_frame(input logic [7:0] d, input logic n9, input string req);
        logic [11:0] bits;
        int len;
        expect_frame(d, n9, bits, len);
        for (int k = 0; k < len; k++) begin
            for (int j = 0; j < P; j++) begin
                if (j == 0 || j == P - 1) chk(ser_out == bits[k], req, ser_out, bits[k]);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(ser_oe == 0, "R11", ser_oe, 0);
        chk(hold_empty == 1, "R11", hold_empty, 1);
        chk(tx_idle == 1, "R11", tx_idle, 1);
        rst_n = 1'b1;
        @(negedge clk);
        tx_en = 1'b1;
        repeat (2) @(negedge clk);
        chk(ser_oe == 1, "R10", ser_oe, 1);
        chk(ser_out == 1, "R10", ser_out, 1);
        chk(tx_idle == 1, "R10", tx_idle, 1);

        // Sweep of every configuration (R1 R2 R3 R4 R5)
        for (int cfg = 0; cfg < 32; cfg++) begin
            for (int di = 0; di < 4; di++) begin
                logic [7:0] d;
                logic n9;
                d = (di == 0) ? 8'h00 : (di == 1) ? 8'hFF : 8'((cfg * 37 + di * 91 + 5) & 255);
                n9 = logic'(di & 1) ^ logic'(cfg & 1);
                @(negedge clk);
                cfg_nine = cfg[0]; cfg_par_en = cfg[1]; cfg_par_odd = cfg[2];
                cfg_addr_en = cfg[3]; cfg_two_stop = cfg[4];
                write_char(d, n9);
                wait_start("R1");
                check_frame(d, n9, "R1_R2_R3_R4_R5");
                chk(tx_idle == 1, "R10", tx_idle, 1);
                chk(ser_out == 1, "R10", ser_out, 1);
            end
        end

        // R6 transfer timing, R7 back-to-back chaining with overwrite
        @(negedge clk);
        cfg_nine = 0; cfg_par_en = 0; cfg_par_odd = 0; cfg_addr_en = 0; cfg_two_stop = 0;
        @(negedge clk);
        wr_stb = 1'b1; wr_data = 8'h5A; wr_nine = 1'b0;
        @(negedge clk);
        wr_stb = 1'b0;
        chk(hold_empty == 0, "R6", hold_empty, 0);
        @(negedge clk);
        chk(hold_empty == 1, "R6", hold_empty, 1);
        wait_start("R8");
        fork
            check_frame(8'h5A, 1'b0, "R7");
            begin
                write_char(8'h11, 1'b0);
                write_char(8'hC3, 1'b0);
                repeat (3 * P) @(negedge clk);
                chk(hold_empty == 0, "R7", hold_empty, 0);
            end
        join
        check_frame(8'hC3, 1'b0, "R7_R6");
        chk(tx_idle == 1, "R10", tx_idle, 1);

        // R8 data written while disabled
        @(negedge clk);
        tx_en = 1'b0;
        write_char(8'h96, 1'b1);
        repeat (3 * P) @(negedge clk);
        chk(ser_oe == 0, "R8", ser_oe, 0);
        chk(hold_empty == 0, "R8", hold_empty, 0);
        chk(tx_idle == 0, "R10", tx_idle, 0);
        tx_en = 1'b1;
        wait_start("R8");
        check_frame(8'h96, 1'b1, "R8");

        // R9 abort mid-frame with a character waiting
        write_char(8'hE7, 1'b0);
        wait_start("R9");
        write_char(8'h3D, 1'b0);
        repeat (3 * P) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(ser_oe == 0, "R9", ser_oe, 0);
        chk(hold_empty == 0, "R9", hold_empty, 0);
        repeat (2 * P) @(negedge clk);
        tx_en = 1'b1;
        @(negedge clk);
        chk(ser_out == 1, "R9", ser_out, 1);
        wait_start("R9");
        check_frame(8'h3D, 1'b0, "R9");

        // R9 abort with nothing waiting: line stays high after re-enable
        write_char(8'h0F, 1'b0);
        wait_start("R9");
        repeat (2 * P) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(ser_oe == 0, "R9", ser_oe, 0);
        tx_en = 1'b1;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 6 * P; k++) begin
            chk(ser_out == 1 && ser_oe == 1, "R9", ser_out, 1);
            @(negedge clk);
        end
        chk(tx_idle == 1, "R10", tx_idle, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule